// File: doc/BRIEF.md
# Transactional MESI Cache Line Controller

This block keeps the coherence state of a small array of private cache lines. Besides the four usual MESI states it has two speculative ones. A transactional store leaves its line privately owned and invisible to other cores. A transactional read that another core has already claimed for writing is held as a threatened copy. When a transaction ends, a single-cycle flash operation either publishes or discards all the speculative state of the array at once. Two transactions may own the same line speculatively at the same time. The block does not invalidate either of them when the second one writes.

The core side issues one operation per cycle: plain load, plain store, transactional load or transactional store. Each names a line index. A miss or an upgrade sends one coherence request (GETS, GETX or TGETX) out of the block. The controller then waits in `CTL_WAIT` until the fill arrives and returns to `CTL_IDLE`. Forwarded requests from the directory are answered one cycle later, with a response code and a flag that says data goes along with the response. A local write-back pulse is raised when a modified line has to be written to L2 before it turns speculative.

The controller state machine has two states. `CTL_IDLE` accepts operations. `CTL_WAIT` holds one outstanding miss and leaves on a fill. Each line takes one of six states: I, S, E, M, TI and TMI. The transitions are named in the requirements below.

Top module: `tmesi_line_ctrl`

## Requirements
- R1: Each line's state is exposed on `line_state` as three bits {M,V,T} at bits [3i+2:3i], with I=000, TI=001, S=010, M=100, TMI=101 and E=110; no other code ever appears, and reset puts every line in I.
- R2: Requests use the codes GETS=0, GETX=1 and TGETX=2, and appear one cycle after the operation is accepted. A load or transactional load to I issues GETS. A plain store to S, I or TI issues GETX. A transactional store to E, S, I or TI issues TGETX. At most one miss is outstanding, and `op_ready` stays low from acceptance until the fill.
- R3: A fill sets the line state from the request that caused the miss. Transactional store → TMI. Plain store → M. A read with `fill_threat` → TI for a transactional load, or stays I for a plain load. Otherwise a read → S if `fill_shared` is set, else E.
- R4: Loads of either kind that find M, E, S, TMI or TI are hits with no request and no state change. A plain store to E silently becomes M. A plain store to M or TMI is a hit.
- R5: A transactional store to M pulses `wb_valid` one cycle later with no request, and the line becomes TMI. A transactional store to TMI does nothing visible.
- R6: Response codes are NONE=0, SHARED=1, THREATENED=2 and INV-ACK=3. Any forwarded request to a TMI line is answered THREATENED, and the line stays TMI.
- R7: A forwarded GETX or TGETX to M, E or S is answered INV-ACK and the line goes to I. `rsp_flush` is set only when the line was M.
- R8: A forwarded GETS is handled by state. M → S with SHARED and flush. E → S with SHARED. S stays S with SHARED. I gives NONE. TI stays TI, answering SHARED to GETS and INV-ACK to GETX/TGETX.
- R9: A `commit` pulse clears every T bit in one cycle: TMI→M, TI→I, and other lines are unchanged.
- R10: An `abort` pulse clears M wherever T is set and then all T bits, in one cycle: TMI→I, TI→I, and other lines are unchanged.
- R11: `op_ready` is low in any cycle with `commit` or `abort`. It is also low when a forwarded request targets the same line as the offered operation. A stalled operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Local operation offered |
| op_kind | input | 2 | 0 load, 1 store, 2 transactional load, 3 transactional store |
| op_line | input | log2(NLINES) | Line index of the operation |
| op_ready | output | 1 | Operation accepted this cycle when high |
| fill_valid | input | 1 | Fill for the outstanding miss |
| fill_threat | input | 1 | Fill came back Threatened |
| fill_shared | input | 1 | Other sharers exist (read fills) |
| rq_valid | input | 1 | Forwarded remote request |
| rq_kind | input | 2 | 0 GETS, 1 GETX, 2 TGETX |
| rq_line | input | log2(NLINES) | Line index of the remote request |
| commit | input | 1 | Flash commit pulse |
| abort | input | 1 | Flash abort pulse |
| req_valid | output | 1 | Coherence request issued |
| req_kind | output | 2 | Request code |
| req_line | output | log2(NLINES) | Request line index |
| wb_valid | output | 1 | Write-back of a modified line to L2 |
| wb_line | output | log2(NLINES) | Write-back line index |
| rsp_valid | output | 1 | Response to a remote request |
| rsp_kind | output | 2 | Response code |
| rsp_flush | output | 1 | Data accompanies the response |
| rsp_line | output | log2(NLINES) | Response line index |
| line_state | output | 3*NLINES | Per-line {M,V,T} state bits |

## Verification
On every cycle the bound checker covers the following. Only the six legal encodings appear. A request follows only an accepted operation and is never back to back. Remote requests to TMI lines are answered THREATENED. Invalidating requests to valid non-speculative lines are answered INV-ACK. Flash pulses stall the core and leave no T bit behind. The scenario bench covers the rest: the exact state each fill produces, silent upgrades, the write-back before a modified line turns speculative, TI answers, which lines commit and abort keep, and the effect-free stalled operation. All of these depend on chains of several operations.

// File: rtl/tmesi_pkg.sv
package tmesi_pkg;

    localparam int LSW = 3;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_TLOAD  = 2'd2,
        OP_TSTORE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CQ_GETS  = 2'd0,
        CQ_GETX  = 2'd1,
        CQ_TGETX = 2'd2,
        CQ_RSVD  = 2'd3
    } coh_e;

    typedef enum logic [1:0] {
        RS_NONE   = 2'd0,
        RS_SHARED = 2'd1,
        RS_THREAT = 2'd2,
        RS_INVACK = 2'd3
    } rsp_e;

    // {M,V,T}
    typedef enum logic [2:0] {
        LS_I   = 3'b000,
        LS_TI  = 3'b001,
        LS_S   = 3'b010,
        LS_M   = 3'b100,
        LS_TMI = 3'b101,
        LS_E   = 3'b110
    } lst_e;

    function automatic lst_e to_lst(logic [2:0] b);
        case (b)
            3'b001:  return LS_TI;
            3'b010:  return LS_S;
            3'b100:  return LS_M;
            3'b101:  return LS_TMI;
            3'b110:  return LS_E;
            default: return LS_I;
        endcase
    endfunction

endpackage

// File: rtl/tmesi_snoop.sv
module tmesi_snoop
    import tmesi_pkg::*;
(
    input  logic [LSW-1:0] cur,
    input  logic [1:0]     kind,
    output logic [LSW-1:0] nxt,
    output logic [1:0]     rsp,
    output logic           flush
);
    lst_e s;
    logic is_gets;

    assign s       = to_lst(cur);
    assign is_gets = (coh_e'(kind) == CQ_GETS);

    always_comb begin
        nxt   = cur;
        rsp   = RS_NONE;
        flush = 1'b0;
        unique case (s)
            LS_M: begin
                flush = 1'b1;
                if (is_gets) begin
                    nxt = LS_S;
                    rsp = RS_SHARED;
                end else begin
                    nxt = LS_I;
                    rsp = RS_INVACK;
                end
            end
            LS_E, LS_S: begin
                if (is_gets) begin
                    nxt = LS_S;
                    rsp = RS_SHARED;
                end else begin
                    nxt = LS_I;
                    rsp = RS_INVACK;
                end
            end
            LS_TMI: begin
                nxt = LS_TMI;
                rsp = RS_THREAT;
            end
            LS_TI: begin
                nxt = LS_TI;
                rsp = is_gets ? RS_SHARED : RS_INVACK;
            end
            LS_I: begin
                nxt = LS_I;
                rsp = is_gets ? RS_NONE : RS_INVACK;
            end
            default: begin
                nxt = LS_I;
                rsp = RS_NONE;
            end
        endcase
    end
endmodule

// File: rtl/tmesi_local.sv
module tmesi_local
    import tmesi_pkg::*;
(
    input  logic [LSW-1:0] cur,
    input  logic [1:0]     kind,
    output logic           miss,
    output logic [1:0]     miss_kind,
    output logic [LSW-1:0] nxt,
    output logic           wb
);
    lst_e s;
    op_e  k;

    assign s = to_lst(cur);
    assign k = op_e'(kind);

    always_comb begin
        miss      = 1'b0;
        miss_kind = CQ_GETS;
        nxt       = cur;
        wb        = 1'b0;
        unique case (k)
            OP_LOAD, OP_TLOAD: begin
                if (s == LS_I) begin
                    miss      = 1'b1;
                    miss_kind = CQ_GETS;
                end
            end
            OP_STORE: begin
                unique case (s)
                    LS_M, LS_TMI: nxt = cur;
                    LS_E:         nxt = LS_M;
                    default: begin
                        miss      = 1'b1;
                        miss_kind = CQ_GETX;
                    end
                endcase
            end
            OP_TSTORE: begin
                unique case (s)
                    LS_TMI: nxt = cur;
                    LS_M: begin
                        nxt = LS_TMI;
                        wb  = 1'b1;
                    end
                    default: begin
                        miss      = 1'b1;
                        miss_kind = CQ_TGETX;
                    end
                endcase
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/tmesi_fill.sv
module tmesi_fill
    import tmesi_pkg::*;
(
    input  logic [1:0]     pend_op,
    input  logic           threat,
    input  logic           shared,
    output logic [LSW-1:0] nxt
);
    always_comb begin
        unique case (op_e'(pend_op))
            OP_STORE:  nxt = LS_M;
            OP_TSTORE: nxt = LS_TMI;
            OP_TLOAD: begin
                if (threat)      nxt = LS_TI;
                else if (shared) nxt = LS_S;
                else             nxt = LS_E;
            end
            default: begin
                if (threat)      nxt = LS_I;
                else if (shared) nxt = LS_S;
                else             nxt = LS_E;
            end
        endcase
    end
endmodule

// File: rtl/tmesi_line_ctrl.sv
module tmesi_line_ctrl
    import tmesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [1:0]            op_kind,
    input  logic [IDXW-1:0]       op_line,
    output logic                  op_ready,
    input  logic                  fill_valid,
    input  logic                  fill_threat,
    input  logic                  fill_shared,
    input  logic                  rq_valid,
    input  logic [1:0]            rq_kind,
    input  logic [IDXW-1:0]       rq_line,
    input  logic                  commit,
    input  logic                  abort,
    output logic                  req_valid,
    output logic [1:0]            req_kind,
    output logic [IDXW-1:0]       req_line,
    output logic                  wb_valid,
    output logic [IDXW-1:0]       wb_line,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_kind,
    output logic                  rsp_flush,
    output logic [IDXW-1:0]       rsp_line,
    output logic [LSW*NLINES-1:0] line_state
);
    typedef enum logic {CTL_IDLE, CTL_WAIT} ctl_e;

    ctl_e ctl_q, ctl_d;

    logic [LSW-1:0]  line_cur [NLINES];
    logic [IDXW-1:0] pend_line;
    logic [1:0]      pend_op;

    logic            accept;
    logic            fill_fire;
    logic            loc_miss, loc_wb;
    logic [1:0]      loc_kind;
    logic [LSW-1:0]  loc_next;
    logic [LSW-1:0]  sn_next;
    logic [1:0]      sn_rsp;
    logic            sn_flush;
    logic [LSW-1:0]  fl_next;

    assign op_ready  = (ctl_q == CTL_IDLE) && !commit && !abort &&
                       !(rq_valid && (rq_line == op_line));
    assign accept    = op_valid && op_ready;
    assign fill_fire = fill_valid && (ctl_q == CTL_WAIT);

    tmesi_local u_local (
        .cur       (line_cur[op_line]),
        .kind      (op_kind),
        .miss      (loc_miss),
        .miss_kind (loc_kind),
        .nxt       (loc_next),
        .wb        (loc_wb)
    );

    tmesi_snoop u_snoop (
        .cur   (line_cur[rq_line]),
        .kind  (rq_kind),
        .nxt   (sn_next),
        .rsp   (sn_rsp),
        .flush (sn_flush)
    );

    tmesi_fill u_fill (
        .pend_op (pend_op),
        .threat  (fill_threat),
        .shared  (fill_shared),
        .nxt     (fl_next)
    );

    // controller state register
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_IDLE;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_IDLE: if (accept && loc_miss) ctl_d = CTL_WAIT;
            CTL_WAIT: if (fill_valid)         ctl_d = CTL_IDLE;
            default:                          ctl_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_line <= '0;
            pend_op   <= OP_LOAD;
        end else if (accept && loc_miss) begin
            pend_line <= op_line;
            pend_op   <= op_kind;
        end
    end

    // per-line state array
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [LSW-1:0] st_q, st_d;
        logic           hit_rq, hit_op, hit_fill;

        assign hit_rq   = rq_valid  && (rq_line   == IDXW'(g));
        assign hit_op   = accept    && !loc_miss && (op_line == IDXW'(g));
        assign hit_fill = fill_fire && (pend_line == IDXW'(g));

        always_comb begin
            st_d = st_q;
            if (hit_rq)   st_d = sn_next;
            if (hit_op)   st_d = loc_next;
            if (hit_fill) st_d = fl_next;
            if (abort) begin
                if (st_d[0]) st_d[2] = 1'b0;
                st_d[0] = 1'b0;
            end else if (commit) begin
                st_d[0] = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= LS_I;
            else        st_q <= st_d;
        end

        assign line_cur[g]              = st_q;
        assign line_state[g*LSW +: LSW] = st_q;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_kind  <= CQ_GETS;
            req_line  <= '0;
            wb_valid  <= 1'b0;
            wb_line   <= '0;
            rsp_valid <= 1'b0;
            rsp_kind  <= RS_NONE;
            rsp_flush <= 1'b0;
            rsp_line  <= '0;
        end else begin
            req_valid <= accept && loc_miss;
            req_kind  <= loc_kind;
            req_line  <= op_line;
            wb_valid  <= accept && loc_wb;
            wb_line   <= op_line;
            rsp_valid <= rq_valid;
            rsp_kind  <= sn_rsp;
            rsp_flush <= rq_valid && sn_flush;
            rsp_line  <= rq_line;
        end
    end
endmodule

// File: rtl/tmesi_line_ctrl_chk.sv
module tmesi_line_ctrl_chk
    import tmesi_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW  = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic                  op_ready,
    input logic                  rq_valid,
    input logic [1:0]            rq_kind,
    input logic [IDXW-1:0]       rq_line,
    input logic                  commit,
    input logic                  abort,
    input logic                  req_valid,
    input logic                  rsp_valid,
    input logic [1:0]            rsp_kind,
    input logic [LSW*NLINES-1:0] line_state
);
    logic [NLINES-1:0] t_vec;
    logic [LSW-1:0]    rq_st;

    always_comb begin
        rq_st = '0;
        for (int i = 0; i < NLINES; i++) begin
            t_vec[i] = line_state[i*LSW];
            if (rq_line == IDXW'(i)) rq_st = line_state[i*LSW +: LSW];
        end
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_enc
        AST_LEGAL_ENC: assert property (@(posedge clk) disable iff (!rst_n)
            line_state[g*LSW +: LSW] inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110}); // R1
    end

    AST_REQ_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(op_valid && op_ready)); // R2

    AST_ONE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !op_ready); // R2

    AST_TMI_THREAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_st == 3'b101) |=> (rsp_valid && rsp_kind == 2'd2)); // R6

    AST_SNOOP_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_kind != 2'd0 && rq_st inside {3'b100, 3'b110, 3'b010})
        |=> (rsp_valid && rsp_kind == 2'd3)); // R7

    AST_COMMIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (t_vec == '0)); // R9

    AST_ABORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (t_vec == '0)); // R10

    AST_FLASH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || abort) |-> !op_ready); // R11
endmodule

bind tmesi_line_ctrl tmesi_line_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .rq_valid   (rq_valid),
    .rq_kind    (rq_kind),
    .rq_line    (rq_line),
    .commit     (commit),
    .abort      (abort),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_kind   (rsp_kind),
    .line_state (line_state)
);

// File: tb/tmesi_line_ctrl_bench.sv
module tmesi_line_ctrl_bench;
    localparam int NL = 8;
    localparam int IW = 3;

    localparam int LOAD = 0, STORE = 1, TLOAD = 2, TSTORE = 3;
    localparam int GETS = 0, GETX = 1, TGETX = 2;
    localparam int NONE = 0, SHARED = 1, THREAT = 2, INVACK = 3;
    localparam int SI = 0, STI = 1, SS = 2, SM = 4, STMI = 5, SE = 6;

    logic clk = 0, rst_n = 0;
    logic op_valid = 0, fill_valid = 0, fill_threat = 0, fill_shared = 0;
    logic rq_valid = 0, commit = 0, abort = 0;
    logic [1:0] op_kind = 0, rq_kind = 0;
    logic [IW-1:0] op_line = 0, rq_line = 0;
    logic op_ready, req_valid, wb_valid, rsp_valid, rsp_flush;
    logic [1:0] req_kind, rsp_kind;
    logic [IW-1:0] req_line, wb_line, rsp_line;
    logic [3*NL-1:0] line_state;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    int q_req[$], q_wb[$], q_rsp[$];

    always #10 clk = ~clk;

    tmesi_line_ctrl #(.NLINES(NL)) u_tmesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_line(op_line), .op_ready(op_ready), .fill_valid(fill_valid),
        .fill_threat(fill_threat), .fill_shared(fill_shared), .rq_valid(rq_valid),
        .rq_kind(rq_kind), .rq_line(rq_line), .commit(commit), .abort(abort),
        .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
        .wb_valid(wb_valid), .wb_line(wb_line), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_flush(rsp_flush), .rsp_line(rsp_line),
        .line_state(line_state)
    );

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pop expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (req_valid) begin
                if (q_req.size() == 0) chk("R2 unexpected request", int'(req_kind)*256 + int'(req_line), -1);
                else chk("R2 request", int'(req_kind)*256 + int'(req_line), q_req.pop_front());
            end
            if (wb_valid) begin
                if (q_wb.size() == 0) chk("R5 unexpected writeback", int'(wb_line), -1);
                else chk("R5 writeback", int'(wb_line), q_wb.pop_front());
            end
            if (rsp_valid) begin
                if (q_rsp.size() == 0) chk("R6 R7 R8 unexpected response", 0, -1);
                else chk("R6 R7 R8 response",
                         int'(rsp_kind)*512 + int'(rsp_flush)*256 + int'(rsp_line),
                         q_rsp.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic op(int k, int l);
        @(negedge clk);
        op_valid = 1; op_kind = 2'(k); op_line = IW'(l);
        #1 chk("R11 op_ready", int'(op_ready), 1);
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic fill(bit thr, bit shr);
        @(negedge clk);
        fill_valid = 1; fill_threat = thr; fill_shared = shr;
        @(negedge clk);
        fill_valid = 0; fill_threat = 0; fill_shared = 0;
    endtask

    task automatic snoop(int k, int l, int rsp, int fl);
        @(negedge clk);
        q_rsp.push_back(rsp*512 + fl*256 + l);
        rq_valid = 1; rq_kind = 2'(k); rq_line = IW'(l);
        @(negedge clk);
        rq_valid = 0;
    endtask

    task automatic flash(bit c, bit a);
        @(negedge clk);
        commit = c; abort = a;
        @(negedge clk);
        commit = 0; abort = 0;
    endtask

    task automatic st(int l, int exp, string tag);
        chk(tag, int'(line_state[l*3 +: 3]), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < NL; i++) st(i, SI, "R1 reset state");
        chk("R11 ready after reset", int'(op_ready), 1);

        // miss, fill exclusive, silent upgrade, TStore from M
        q_req.push_back(GETS*256 + 0);
        op(LOAD, 0);
        chk("R2 busy while waiting", int'(op_ready), 0);
        fill(0, 0);
        st(0, SE, "R3 read fill exclusive");
        op(STORE, 0);
        st(0, SM, "R4 store on E");
        q_wb.push_back(0);
        op(TSTORE, 0);
        st(0, STMI, "R5 TStore on M");
        op(TSTORE, 0);
        st(0, STMI, "R5 TStore on TMI");
        snoop(GETS, 0, THREAT, 0);
        snoop(GETX, 0, THREAT, 0);
        st(0, STMI, "R6 TMI kept");
        flash(1, 0);
        st(0, SM, "R9 TMI commit to M");
        snoop(GETX, 0, INVACK, 1);
        st(0, SI, "R7 M invalidated");

        // threatened fills and shared fill
        q_req.push_back(GETS*256 + 1);
        op(TLOAD, 1); fill(1, 0);
        st(1, STI, "R3 threatened TLoad");
        q_req.push_back(GETS*256 + 2);
        op(LOAD, 2); fill(1, 0);
        st(2, SI, "R3 threatened Load");
        q_req.push_back(GETS*256 + 3);
        op(LOAD, 3); fill(0, 1);
        st(3, SS, "R3 shared fill");
        op(LOAD, 1);
        st(1, STI, "R4 load hit on TI");
        snoop(GETS, 3, SHARED, 0);
        st(3, SS, "R8 S on GETS");
        snoop(GETS, 1, SHARED, 0);
        snoop(TGETX, 1, INVACK, 0);
        st(1, STI, "R8 TI kept");

        q_req.push_back(TGETX*256 + 3);
        op(TSTORE, 3); fill(0, 0);
        st(3, STMI, "R2 TStore upgrade from S");
        q_req.push_back(GETX*256 + 7);
        op(STORE, 7); fill(0, 0);
        st(7, SM, "R3 store fill");
        flash(0, 1);
        st(1, SI, "R10 TI abort");
        st(3, SI, "R10 TMI abort");
        st(7, SM, "R10 M untouched");

        q_req.push_back(GETS*256 + 4);
        op(LOAD, 4); fill(0, 0);
        snoop(TGETX, 4, INVACK, 0);
        st(4, SI, "R7 E invalidated");
        snoop(GETS, 5, NONE, 0);
        snoop(GETS, 7, SHARED, 1);
        st(7, SS, "R8 M downgraded");

        // commit with TI and TMI present
        q_req.push_back(GETS*256 + 2);
        op(TLOAD, 2); fill(1, 0);
        q_req.push_back(TGETX*256 + 5);
        op(TSTORE, 5); fill(0, 0);
        flash(1, 0);
        st(2, SI, "R9 TI commit to I");
        st(5, SM, "R9 TMI commit to M");

        // stall under flash: operation must not take effect
        @(negedge clk);
        op_valid = 1; op_kind = 2'(LOAD); op_line = 3'd6; commit = 1;
        #1 chk("R11 stall on commit", int'(op_ready), 0);
        @(negedge clk);
        commit = 0;
        st(6, SI, "R11 stalled op no effect");
        q_req.push_back(GETS*256 + 6);
        #1 chk("R11 ready after commit", int'(op_ready), 1);
        @(negedge clk);
        op_valid = 0;
        fill(0, 0);
        st(6, SE, "R3 fill after stall");

        // stall on same-line remote request
        @(negedge clk);
        op_valid = 1; op_kind = 2'(STORE); op_line = 3'd6;
        rq_valid = 1; rq_kind = 2'(GETS); rq_line = 3'd6;
        q_rsp.push_back(SHARED*512 + 6);
        #1 chk("R11 stall on same line", int'(op_ready), 0);
        @(negedge clk);
        rq_valid = 0;
        st(6, SS, "R11 remote won, store held");
        q_req.push_back(GETX*256 + 6);
        @(negedge clk);
        op_valid = 0;
        fill(0, 0);
        st(6, SM, "R2 store upgrade from S");

        repeat (2) @(negedge clk);
        chk("R2 pending requests", q_req.size(), 0);
        chk("R5 pending writebacks", q_wb.size(), 0);
        chk("R8 pending responses", q_rsp.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule